// File: doc/BRIEF.md
# Phase-Shifted PWM Channel Output Stage

This block turns a free-running 16-bit phase value, shared by many channels, into one registered PWM pin. The phase and the channel's settings are fractions of a PWM period in units of 2^-16. The pulse starts at a programmable delay. It stays high for the programmed duty length, and the pulse may run past the end of the period into the start of the next one.

A 4-bit resolution code selects how many of the top bits of the phase, the delay and the duty take part in the compare. All lower bits are cleared. The channel can be turned off, and its polarity can be inverted. Duty changes take effect only when the quantized phase is zero, so a change made in the middle of a period never cuts a pulse short.

Top module: `pwm_phase_channel`

## Requirements
- R1: While `rst_n` is low, `pwm_o` is 0.
- R2: With `enable_i`=1 and `invert_i`=0, the channel is active when (phase_q - delay_q) mod 2^16 < duty_q. Here _q is the value after quantization (R4). The rising edge falls on the slice where phase_q equals delay_q.
- R3: The active window wraps across the period boundary. A delay near the end of the period gives a pulse that covers the end of one period and the start of the next.
- R4: For a resolution code r (0..15), only bits [15:15-r] of the phase, the delay and the duty are used. The lower bits are treated as zero.
- R5: With `enable_i`=0, `pwm_o` holds the inactive level: 0 when `invert_i`=0 and 1 when `invert_i`=1.
- R6: With `invert_i`=1, the output is active-low: `pwm_o` is the complement of the R2 result.
- R7: The duty value is sampled on every clock whose quantized phase is zero, and it applies from that clock on. On all other clocks the last sampled value is used, even if `duty_i` changes. After reset the sampled value is zero.
- R8: A duty value that quantizes to zero keeps the channel inactive at every phase.
- R9: `pwm_o` is a register. It shows the result for the inputs present on the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| phase_i | input | 16 | Shared phase value, fraction of a period |
| resn_i | input | 4 | Resolution code; r keeps the top r+1 bits |
| delay_i | input | 16 | Rising-edge phase offset |
| duty_i | input | 16 | Requested duty length |
| enable_i | input | 1 | Channel enable |
| invert_i | input | 1 | Active-low output select |
| pwm_o | output | 1 | Registered PWM output |

## Verification
The assertions check on every cycle that a disabled channel sits at its inactive level. They also check that a zero effective duty never yields an active output, that the sampled duty does not move away from phase zero, and that an enabled channel goes active in the slice after the phase reaches the delay. Other behaviours depend on chosen phase sequences, so only the bench scenarios can show them. These are the exact window boundaries, the wrap across the period end, the truncation of each operand at low resolutions, and the deferral of a duty change made in the middle of a period.

// File: rtl/pwm_phase_channel.sv
module pwm_phase_channel #(
  parameter int PW = 16,
  parameter int RW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] phase_i,
  input  logic [RW-1:0] resn_i,
  input  logic [PW-1:0] delay_i,
  input  logic [PW-1:0] duty_i,
  input  logic          enable_i,
  input  logic          invert_i,
  output logic          pwm_o
);

  localparam int MSB = PW - 1;

  logic [PW-1:0] keep_mask;
  logic [PW-1:0] phase_q, delay_q, duty_q;
  logic [PW-1:0] duty_lat, duty_eff, offset;
  logic          at_start, active;

  assign keep_mask = {PW{1'b1}} << (MSB - int'(resn_i));
  assign phase_q   = phase_i & keep_mask;
  assign delay_q   = delay_i & keep_mask;
  assign duty_q    = duty_i  & keep_mask;
  assign at_start  = (phase_q == '0);

  // New duty applies only from the first slice of a period
  assign duty_eff = at_start ? duty_q : (duty_lat & keep_mask);
  assign offset   = phase_q - delay_q;
  assign active   = offset < duty_eff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        duty_lat <= '0;
    else if (at_start) duty_lat <= duty_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pwm_o <= 1'b0;
    else        pwm_o <= enable_i ? (active ^ invert_i) : invert_i;
  end

  assert_off_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable_i && !invert_i) |=> !pwm_o);

  assert_off_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable_i && invert_i) |=> pwm_o);

  assert_zero_duty_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_i && duty_eff == '0) |=> (pwm_o == $past(invert_i)));

  assert_duty_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !at_start |=> $stable(duty_lat));

  assert_edge_at_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_i && !invert_i && phase_q == delay_q && duty_eff != '0) |=> pwm_o);

endmodule

// File: tb/pwm_phase_channel_tb.sv
module pwm_phase_channel_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] phase_i = '0, delay_i = '0, duty_i = '0;
  logic [3:0]  resn_i = 4'd15;
  logic        enable_i = 1'b0, invert_i = 1'b0;
  logic        pwm_o;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  pwm_phase_channel dut_i (
    .clk(clk), .rst_n(rst_n), .phase_i(phase_i), .resn_i(resn_i),
    .delay_i(delay_i), .duty_i(duty_i), .enable_i(enable_i),
    .invert_i(invert_i), .pwm_o(pwm_o)
  );

  task automatic check(input logic exp, input string tag);
    checks++;
    if (pwm_o !== exp) begin
      errors++;
      $display("FAIL %s: pwm_o=%0b expected %0b (phase=%h)", tag, pwm_o, exp, phase_i);
    end
  endtask

  task automatic step(input logic [15:0] ph, input logic exp, input string tag);
    @(negedge clk);
    phase_i = ph;
    @(posedge clk);
    #2;
    check(exp, tag);
  endtask

  task automatic setup(input logic [3:0] r, input logic [15:0] dl, input logic [15:0] dt,
                       input logic en, input logic inv);
    @(negedge clk);
    resn_i = r; delay_i = dl; duty_i = dt; enable_i = en; invert_i = inv;
  endtask

  task automatic t_reset;
    enable_i = 1'b1; invert_i = 1'b1; duty_i = 16'hFFFF;
    repeat (3) @(posedge clk);
    #2 check(1'b0, "R1 reset");
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_basic;
    setup(15, 16'h0000, 16'h4000, 1, 0);
    step(16'h0000, 1, "R2 start");
    step(16'h1000, 1, "R2 inside");
    step(16'h4000, 0, "R2 end boundary");
    step(16'h5000, 0, "R9 registered low");
    setup(15, 16'h2000, 16'h1000, 1, 0);
    step(16'h0000, 0, "R2 before delay");
    step(16'h1FFF, 0, "R2 just before edge");
    step(16'h2000, 1, "R2 rising at delay");
    step(16'h3000, 0, "R2 after window");
  endtask

  task automatic t_wrap;
    setup(15, 16'hC000, 16'h8000, 1, 0);
    step(16'h0000, 1, "R3 wrap start");
    step(16'hE000, 1, "R3 before boundary");
    step(16'h3FFF, 1, "R3 last slice");
    step(16'h4000, 0, "R3 window end");
    step(16'hB000, 0, "R3 before delay");
  endtask

  task automatic t_quant;
    setup(1, 16'h3FFF, 16'h7FFF, 1, 0);
    step(16'h0000, 1, "R4 delay truncated");
    step(16'h3FFF, 1, "R4 phase truncated");
    step(16'h5000, 0, "R4 duty truncated");
    setup(1, 16'h7000, 16'h7FFF, 1, 0);
    step(16'h0000, 0, "R4 delay 0x4000");
    step(16'h4000, 1, "R4 at delay");
    step(16'h7FFF, 1, "R4 same slice");
    step(16'h8000, 0, "R4 next slice");
  endtask

  task automatic t_zero;
    setup(0, 16'h0000, 16'h7FFF, 1, 0);
    step(16'h0000, 0, "R8 zero duty start");
    step(16'h4000, 0, "R8 zero duty mid");
    step(16'hC000, 0, "R8 zero duty late");
  endtask

  task automatic t_disable;
    setup(15, 16'h0000, 16'hFFFF, 0, 0);
    step(16'h0000, 0, "R5 off low");
    step(16'h1000, 0, "R5 off low mid");
    setup(15, 16'h0000, 16'hFFFF, 0, 1);
    step(16'h1000, 1, "R5 off inverted");
  endtask

  task automatic t_invert;
    setup(15, 16'h0000, 16'h4000, 1, 1);
    step(16'h0000, 0, "R6 active low");
    step(16'h8000, 1, "R6 idle high");
  endtask

  task automatic t_latch;
    setup(15, 16'h0000, 16'h4000, 1, 0);
    step(16'h0000, 1, "R7 load");
    duty_i = 16'h2000;
    step(16'h3000, 1, "R7 old duty kept");
    step(16'h0000, 1, "R7 reload");
    step(16'h3000, 0, "R7 new duty used");
  endtask

  initial begin
    #(100000 * 8);
    errors++;
    $display("FAIL watchdog R9: run did not finish, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_wrap();
    t_quant();
    t_zero();
    t_disable();
    t_invert();
    t_latch();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule